// File: doc/BRIEF.md
# Serial EEPROM Write-Enable and Page-Write Controller

This block sits behind the serial front-end of a byte-wide serial EEPROM and handles every write into the storage array. The front-end decodes opcodes, the address and data bytes from the serial stream. It sends them here as one-cycle strobes. When chip select is released it also sends a strobe with a flag that says whether the number of clocked bits was a whole number of bytes.

The controller holds the write-enable latch. It collects the data bytes of a write command into a page buffer and decides at chip-select release whether to commit them. It then runs a write cycle with a fixed length. During that cycle it sweeps the buffered bytes into the array through a simple write port. A status byte shows the write-in-progress flag and the write-enable latch. The status-read path in the front-end returns this byte to the host.

Top module: `nvm_page_writer`

## Requirements
- R1: The write-enable latch (status bit 1) is set only on a chip-select release that is byte-aligned and follows a complete enable opcode in the same select period. A write command in that same select period is rejected, because the latch is not yet set.
- R2: A write command is accepted only when the write-enable latch is already set. Otherwise no array write occurs and status bit 0 stays low.
- R3: The write address is 16 bits wide and only its low AW bits are used. The upper bits have no effect on the array location written.
- R4: Data bytes go to consecutive offsets within one page of 2^PW bytes. After the last offset of the page the offset wraps to offset 0 of the same page, and a later byte to the same offset replaces the earlier one.
- R5: A write commits only if chip select is released byte-aligned after at least one complete data byte. Any other release abandons it with no array write and leaves the latch set.
- R6: While a committed write runs, status bit 0 (write in progress) is high for exactly PROG_CLKS clocks. Array writes happen only in that window and touch only the buffered offsets. Other locations keep their contents.
- R7: When the write cycle ends, the write-enable latch clears.
- R8: A disable opcode clears the write-enable latch at once.
- R9: An aligned release after a write command and address but with no data byte performs no write and leaves the latch unchanged.
- R10: During a write cycle the enable, disable and write opcodes are ignored.
- R11: After reset the status byte is zero and no array write is signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_wren | input | 1 | Strobe: enable opcode byte completed |
| op_wrdi | input | 1 | Strobe: disable opcode byte completed |
| op_write | input | 1 | Strobe: write opcode byte completed |
| addr_vld | input | 1 | Strobe: 16-bit address completed |
| addr_in | input | 16 | Received address |
| byte_vld | input | 1 | Strobe: data byte completed |
| byte_in | input | 8 | Received data byte |
| cs_rise | input | 1 | Strobe: chip select released |
| cs_aligned | input | 1 | Bit count at release was a multiple of eight |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | AW | Array write address |
| arr_wdata | output | 8 | Array write data |
| status | output | 8 | Bit 0 write in progress, bit 1 write-enable latch, others zero |

## Verification
On every cycle the assertions check four things. Array writes occur only inside the write-in-progress window and stay within one page. The latch rises only on an aligned chip-select release. A write cycle starts only from an aligned release while the latch is set, and the latch is clear when a cycle ends. The bench scenarios cover what needs history across several commands. These are page wrap and overwrite order, the exact contents of each page, which upper address bits are ignored, and the exact cycle length. They also cover that abandoned, empty or unauthorised writes leave the array and the latch as they were.

// File: rtl/nvm_page_writer.sv
module nvm_page_writer #(
  parameter int AW        = 12,
  parameter int PW        = 5,
  parameter int PROG_CLKS = 64,
  localparam int PAGE     = 1 << PW,
  localparam int TW       = $clog2(PROG_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_wren,
  input  logic          op_wrdi,
  input  logic          op_write,
  input  logic          addr_vld,
  input  logic [15:0]   addr_in,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          cs_rise,
  input  logic          cs_aligned,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic [7:0]    status
);

  logic             wel, wren_pend, busy, collect, have_addr, any_byte;
  logic [AW-1:PW]   page_base;
  logic [PW-1:0]    ptr;
  logic [TW-1:0]    tmr;
  logic [PAGE-1:0]  vld_q;
  logic [7:0]       buf_q [PAGE];

  wire unused_hi = ^addr_in[15:AW];

  wire [PW-1:0] idx     = tmr[PW-1:0];
  wire          in_scan = busy && (tmr < TW'(PAGE));
  wire          take_b  = !busy && byte_vld && collect && have_addr;

  assign arr_we    = in_scan && vld_q[idx];
  assign arr_addr  = {page_base, idx};
  assign arr_wdata = buf_q[idx];
  assign status    = {6'd0, wel, busy};

  always_ff @(posedge clk) begin
    if (take_b) buf_q[ptr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      wren_pend <= 1'b0;
      busy      <= 1'b0;
      collect   <= 1'b0;
      have_addr <= 1'b0;
      any_byte  <= 1'b0;
      page_base <= '0;
      ptr       <= '0;
      tmr       <= '0;
      vld_q     <= '0;
    end else if (busy) begin
      tmr <= tmr + 1'b1;
      if (tmr == TW'(PROG_CLKS - 1)) begin
        busy  <= 1'b0;
        wel   <= 1'b0;
        vld_q <= '0;
      end
    end else begin
      if (op_wren) wren_pend <= 1'b1;
      if (op_wrdi) begin
        wel       <= 1'b0;
        wren_pend <= 1'b0;
      end
      if (op_write && wel) begin
        collect   <= 1'b1;
        have_addr <= 1'b0;
        any_byte  <= 1'b0;
      end
      if (addr_vld && collect && !have_addr) begin
        have_addr <= 1'b1;
        page_base <= addr_in[AW-1:PW];
        ptr       <= addr_in[PW-1:0];
      end
      if (take_b) begin
        vld_q[ptr] <= 1'b1;
        ptr        <= ptr + 1'b1;
        any_byte   <= 1'b1;
      end
      if (cs_rise) begin
        wren_pend <= 1'b0;
        collect   <= 1'b0;
        have_addr <= 1'b0;
        any_byte  <= 1'b0;
        if (wren_pend && cs_aligned) wel <= 1'b1;
        if (collect && any_byte && cs_aligned) begin
          busy <= 1'b1;
          tmr  <= '0;
        end else begin
          vld_q <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/nvm_page_writer_chk.sv
module nvm_page_writer_chk #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_rise,
  input logic          cs_aligned,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr,
  input logic [7:0]    status
);

  p_we_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> status[0]);

  p_page_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && $past(status[0]) && $past(rst_n)) |-> $stable(arr_addr[AW-1:PW]));

  p_wel_set_on_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |-> $past(cs_rise && cs_aligned));

  p_start_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(cs_rise && cs_aligned));

  p_start_needs_wel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(status[1]));

  p_wel_clear_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> !status[1]);

  p_spare_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:2] == 6'd0);

endmodule

bind nvm_page_writer nvm_page_writer_chk #(.AW(AW), .PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_aligned(cs_aligned),
  .arr_we(arr_we), .arr_addr(arr_addr), .status(status));

// File: tb/nvm_page_writer_tb_top.sv
`timescale 1ns/1ps
module nvm_page_writer_tb_top;
  localparam int AW = 12, PW = 5, PCL = 40, PAGE = 1 << PW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_wren = 0, op_wrdi = 0, op_write = 0, addr_vld = 0, byte_vld = 0;
  logic cs_rise = 0, cs_aligned = 0;
  logic [15:0] addr_in = '0;
  logic [7:0]  byte_in = '0;
  logic arr_we;
  logic [AW-1:0] arr_addr;
  logic [7:0] arr_wdata, status;

  int n_chk = 0, n_bad = 0, wr_cnt = 0;
  logic [7:0] exp_mem [1 << AW];
  logic [7:0] got_mem [1 << AW];

  always #2 clk = ~clk;

  nvm_page_writer #(.AW(AW), .PW(PW), .PROG_CLKS(PCL)) dut_i (.*);

  always @(negedge clk) if (rst_n && arr_we) begin
    got_mem[arr_addr] = arr_wdata;
    wr_cnt++;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic release_cs(bit al);
    @(negedge clk); cs_rise = 1'b1; cs_aligned = al;
    @(negedge clk); cs_rise = 1'b0; cs_aligned = 1'b0;
  endtask

  task automatic send_addr(logic [15:0] a);
    @(negedge clk); addr_vld = 1'b1; addr_in = a;
    @(negedge clk); addr_vld = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_in = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic set_wel();
    pulse(op_wren);
    release_cs(1'b1);
  endtask

  function automatic logic [7:0] dat(int s, int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  // Sends a write; returns cycles with status[0] high afterwards.
  task automatic do_write(logic [15:0] a, int n, int s, bit al, output int wip);
    pulse(op_write);
    send_addr(a);
    for (int i = 0; i < n; i++) send_byte(dat(s, i));
    release_cs(al);
    wip = 0;
    while (status[0] && wip < 1000) begin
      wip++;
      @(negedge clk);
    end
  endtask

  task automatic cmp_page(string req, logic [AW-1:0] base);
    for (int k = 0; k < PAGE; k++)
      chk(req, got_mem[base + AW'(k)], exp_mem[base + AW'(k)]);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int wip, w0;
    for (int k = 0; k < (1 << AW); k++) begin exp_mem[k] = '0; got_mem[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 status", status, 0);
    chk("R11 we", arr_we, 0);

    // R2: write without latch
    w0 = wr_cnt;
    do_write(16'h0040, 3, 99, 1'b1, wip);
    chk("R2 writes", wr_cnt - w0, 0);
    chk("R2 wip", wip, 0);

    // R1: enable and write in one select period
    pulse(op_wren);
    chk("R1 wel not yet", status[1], 0);
    pulse(op_write); send_addr(16'h0060); send_byte(8'hAA);
    w0 = wr_cnt;
    release_cs(1'b1);
    repeat (PCL + 2) @(negedge clk);
    chk("R1 same period no write", wr_cnt - w0, 0);
    chk("R1 wel after release", status[1], 1);
    // R8: disable
    pulse(op_wrdi);
    chk("R8 wel cleared", status[1], 0);
    // R1: unaligned release does not set
    pulse(op_wren); release_cs(1'b0);
    chk("R1 unaligned", status[1], 0);

    // R3 R4 R6 R7: sweep of start offsets and lengths
    for (int s = 0; s < PAGE; s++) begin
      logic [15:0] a;
      logic [AW-1:0] base;
      int n;
      a = {4'(s), 12'(s * 96 + s)};
      base = {a[AW-1:PW], 5'd0};
      n = (s * 7) % 40 + 1;
      set_wel();
      chk("R1 wel set", status[1], 1);
      for (int i = 0; i < n; i++)
        exp_mem[base + AW'((a[PW-1:0] + i) % PAGE)] = dat(s, i);
      do_write(a, n, s, 1'b1, wip);
      chk("R6 wip length", wip, PCL);
      chk("R7 wel cleared", status[1], 0);
      cmp_page("R4 page contents", base);
    end
    chk("R3 R6 no stray writes", got_mem[12'h0FE0], exp_mem[12'h0FE0]);

    // R5: unaligned release abandons
    set_wel();
    w0 = wr_cnt;
    do_write(16'h0200, 4, 7, 1'b0, wip);
    chk("R5 no write", wr_cnt - w0, 0);
    chk("R5 no wip", wip, 0);
    chk("R5 wel kept", status[1], 1);

    // R9: zero bytes
    w0 = wr_cnt;
    do_write(16'h0220, 0, 7, 1'b1, wip);
    chk("R9 no write", wr_cnt - w0, 0);
    chk("R9 wel kept", status[1], 1);

    // R10: opcodes ignored while busy
    pulse(op_write); send_addr(16'h0300); send_byte(8'h5C);
    exp_mem[12'h300] = 8'h5C;
    release_cs(1'b1);
    pulse(op_wrdi);
    chk("R10 wel held under wrdi", status[1], 1);
    chk("R10 busy", status[0], 1);
    pulse(op_write); send_addr(16'h0400); send_byte(8'h11); release_cs(1'b1);
    repeat (PCL) @(negedge clk);
    chk("R10 wip done", status[0], 0);
    chk("R10 second write ignored", got_mem[12'h400], 0);
    chk("R6 data", got_mem[12'h300], 8'h5C);
    pulse(op_wren); release_cs(1'b1);
    chk("R10 wel after cycle", status[1], 1);

    finish_run();
  end
endmodule